// File: doc/BRIEF.md
# Gated Register Address Decoder

This block is the slave end of a card-level register bus on which a single master addresses every device. A 9-bit register address is turned into two one-hot select vectors, one for reads and one for writes. Each select is gated by the device's own wakeup condition. A write select also needs both the write control and the write strobe. A read select also needs the read control. A raw copy of the address is passed on as well, gated only by wakeup, for logic that wants to do its own decoding.

Read data and write data use separate internal buses. A bus that nobody drives reads as all ones, which models a pulled-up line. A small register file sits on the low select lines so that the decode path can be exercised from end to end. A write select is registered into a one-cycle write-enable pulse before it reaches the storage. The read path passes through an output gate, and that gate keeps the device silent while the master holds a global tri-state input asserted.

The bus gives no control over the device's global set/reset. Reset here is local: a synchronous, active-low reset that clears only the register file.

Top module: `card_reg_slave`

## Requirements
- R1: `wsel_o` has bit `addr_i` set when `wake_i`, `wr_i` and `wr_stb_i` are all 1. It is all zeros otherwise. It never has more than one bit set.
- R2: `rsel_o` has bit `addr_i` set when `wake_i` and `rd_i` are both 1. It is all zeros otherwise. It never has more than one bit set.
- R3: `raw_addr_o` equals `addr_i` while `wake_i` is 1. It is zero while `wake_i` is 0.
- R4: `rdata_o` is all ones and `rdata_oe_o` is 0 in two cases: no read select is active, or the active read select names an address at or above `NUM_REGS`, where no storage exists.
- R5: A write select seen at clock edge k is captured into a one-cycle enable pulse. The register takes the data sampled at edge k on edge k+1. A read between those two edges returns the previous contents.
- R6: While `gts_i` is 1, `rdata_o` is all ones and `rdata_oe_o` is 0, whatever the address and controls. A write accepted during that time still updates the register file.
- R7: A clock edge with `rst_n` at 0 clears every register to zero. Reset does not change how `gts_i` gates the outputs.
- R8: When a read and a write of the same register fall in one cycle, the read returns the contents held before that write.
- R9: `rdata_oe_o` is 1 exactly when `gts_i` is 0 and a read select names a register below `NUM_REGS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset of the register file |
| wake_i | input | 1 | This device is addressed by the master |
| rd_i | input | 1 | Read cycle |
| wr_i | input | 1 | Write cycle |
| wr_stb_i | input | 1 | Write data valid strobe |
| addr_i | input | ADDR_W (9) | Register address |
| wdata_i | input | DATA_W (8) | Write data bus |
| gts_i | input | 1 | Global output hold-off from the master, 1 = outputs disabled |
| wsel_o | output | 2^ADDR_W (512) | Qualified one-hot write selects |
| rsel_o | output | 2^ADDR_W (512) | Qualified one-hot read selects |
| raw_addr_o | output | ADDR_W (9) | Address gated by wakeup only, zero otherwise |
| rdata_o | output | DATA_W (8) | Read data bus, all ones when undriven |
| rdata_oe_o | output | 1 | Read data actually driven |

## Verification
Two functions can fall in the same cycle: a read and a write of the same register when all four controls are high, and an output hold-off that overlaps either access. The bench drives the read and the write of one register in a single cycle. It expects the old value on the read bus and the new value only after the second clock edge. It then repeats the access with the hold-off raised, and expects an all-ones, undriven bus while the write still takes effect. Decode correctness is judged against a shifted one-hot vector, computed for every address under all sixteen control combinations.

// File: rtl/regdec_pkg.sv
// Package: default geometry shared by the register decoder and its bench.
// Assumes NUM_REGS never exceeds the 2**ADDR_W decoded selects.
package regdec_pkg;
    localparam int DEF_ADDR_W   = 9;
    localparam int DEF_DATA_W   = 8;
    localparam int DEF_NUM_REGS = 8;
endpackage

// File: rtl/regdec_onehot.sv
// Module: one-hot address decoder with a single qualifying enable.
// Purely combinational. Assumes the caller folds all qualifiers into en_i.
module regdec_onehot #(
    parameter int ADDR_W = regdec_pkg::DEF_ADDR_W
) (
    input  logic                     en_i,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic [(1<<ADDR_W)-1:0]   sel_o
);
    localparam int NSEL = 1 << ADDR_W;

    // One comparator per select line, gated by the enable.
    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        assign sel_o[g] = en_i && (addr_i == ADDR_W'(g));
    end
endmodule

// File: rtl/regdec_file.sv
// Module: small register file behind the low select lines.
// Write selects are registered into a one-cycle enable pulse with the data,
// then committed on the next edge. Reads are a one-hot OR mux that returns
// all ones when no line is selected. Assumes at most one rsel bit is set.
module regdec_file #(
    parameter int DATA_W   = regdec_pkg::DEF_DATA_W,
    parameter int NUM_REGS = regdec_pkg::DEF_NUM_REGS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_REGS-1:0]  wsel_i,
    input  logic [NUM_REGS-1:0]  rsel_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 hit_o
);
    logic [NUM_REGS-1:0] we_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   mem [NUM_REGS];
    logic [DATA_W-1:0]   acc;

    // Capture the write pulse and its data one edge after the select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= '0;
            wdata_q <= '0;
        end else begin
            we_q    <= wsel_i;
            wdata_q <= wdata_i;
        end
    end

    // Commit the captured data to the pulsed register, or clear on reset.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n)        mem[i] <= '0;
            else if (we_q[i])  mem[i] <= wdata_q;
        end
    end

    // One-hot OR mux. An undriven bus floats to all ones.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rsel_i[i]) acc = acc | mem[i];
        end
        hit_o   = |rsel_i;
        rdata_o = hit_o ? acc : '1;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        // R5: the pulsed register holds the captured data one edge later.
        p_we_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
            we_q[g] |=> (mem[g] == $past(wdata_q)));
        // R7: reset clears every register.
        p_reset_clears_r7: assert property (@(posedge clk)
            !rst_n |=> (mem[g] == '0));
    end

    // R4: no selected line leaves the bus at its pulled-up level.
    p_idle_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (rdata_o == '1));
endmodule

// File: rtl/regdec_oe_gate.sv
// Module: output hold-off for the read bus.
// While the master's global tri-state is asserted, or nothing is selected,
// the bus is left undriven (all ones) and the enable stays low.
module regdec_oe_gate #(
    parameter int DATA_W = regdec_pkg::DEF_DATA_W
) (
    input  logic              gts_i,
    input  logic              hit_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              oe_o
);
    // Drive only when selected and released by the master.
    always_comb begin
        oe_o   = hit_i && !gts_i;
        data_o = oe_o ? data_i : '1;
    end
endmodule

// File: rtl/card_reg_slave.sv
// Module: gated register address decoder, slave side of the card bus.
// Decodes the address into qualified read and write selects, passes a
// wakeup-gated raw address, and serves a small register file through an
// output gate held off by the master. Assumes NUM_REGS <= 2**ADDR_W.
module card_reg_slave #(
    parameter int ADDR_W   = regdec_pkg::DEF_ADDR_W,
    parameter int DATA_W   = regdec_pkg::DEF_DATA_W,
    parameter int NUM_REGS = regdec_pkg::DEF_NUM_REGS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wake_i,
    input  logic                    rd_i,
    input  logic                    wr_i,
    input  logic                    wr_stb_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    input  logic                    gts_i,
    output logic [(1<<ADDR_W)-1:0]  wsel_o,
    output logic [(1<<ADDR_W)-1:0]  rsel_o,
    output logic [ADDR_W-1:0]       raw_addr_o,
    output logic [DATA_W-1:0]       rdata_o,
    output logic                    rdata_oe_o
);
    logic              wr_ok;
    logic              rd_ok;
    logic [DATA_W-1:0] file_data;
    logic              file_hit;

    // Qualifier sets: write needs strobe too, read needs wakeup and read.
    always_comb begin
        wr_ok = wake_i && wr_i && wr_stb_i;
        rd_ok = wake_i && rd_i;
    end

    // Raw address forwarded under wakeup only, held at zero otherwise.
    always_comb begin
        raw_addr_o = wake_i ? addr_i : '0;
    end

    regdec_onehot #(.ADDR_W(ADDR_W)) u_wdec (
        .en_i   (wr_ok),
        .addr_i (addr_i),
        .sel_o  (wsel_o)
    );

    regdec_onehot #(.ADDR_W(ADDR_W)) u_rdec (
        .en_i   (rd_ok),
        .addr_i (addr_i),
        .sel_o  (rsel_o)
    );

    regdec_file #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wsel_i  (wsel_o[NUM_REGS-1:0]),
        .rsel_i  (rsel_o[NUM_REGS-1:0]),
        .wdata_i (wdata_i),
        .rdata_o (file_data),
        .hit_o   (file_hit)
    );

    regdec_oe_gate #(.DATA_W(DATA_W)) u_gate (
        .gts_i  (gts_i),
        .hit_i  (file_hit),
        .data_i (file_data),
        .data_o (rdata_o),
        .oe_o   (rdata_oe_o)
    );

    // R1: at most one write select, and only under the full write qualifier.
    p_wsel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wsel_o));
    p_wsel_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|wsel_o) |-> (wake_i && wr_i && wr_stb_i));
    // R2: at most one read select, and only under wakeup and read.
    p_rsel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsel_o));
    p_rsel_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsel_o) |-> (wake_i && rd_i));
    // R3: raw address is zero without wakeup.
    p_raw_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_i |-> (raw_addr_o == '0));
    // R6 and R7: hold-off silences the bus in and out of reset.
    p_gts_hold_r6: assert property (@(posedge clk)
        gts_i |-> (!rdata_oe_o && rdata_o == '1));
endmodule

// File: tb/card_reg_slave_tb_top.sv
// Bench: exhaustive decode sweep plus directed register-file sequences.
module card_reg_slave_tb_top;
    localparam int AW = 9;
    localparam int DW = 8;
    localparam int NR = 8;
    localparam int NS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wake_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0, wr_stb_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic          gts_i = 1'b0;
    logic [NS-1:0] wsel_o, rsel_o;
    logic [AW-1:0] raw_addr_o;
    logic [DW-1:0] rdata_o;
    logic          rdata_oe_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [NR];

    card_reg_slave #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR)) dut_i (.*);

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag,
                       input logic [NS-1:0] act, input logic [NS-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        wake_i = 0; rd_i = 0; wr_i = 0; wr_stb_i = 0;
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        wake_i = 1; rd_i = 0; wr_i = 1; wr_stb_i = 1;
        addr_i = AW'(a); wdata_i = d;
        idle();
        @(negedge clk);
    endtask

    task automatic rd_check(input int a, input logic [DW-1:0] exp_d,
                            input logic exp_oe, input string tag);
        @(negedge clk);
        wake_i = 1; rd_i = 1; wr_i = 0; wr_stb_i = 0; addr_i = AW'(a);
        #1;
        chk(rdata_o == exp_d, tag, NS'(rdata_o), NS'(exp_d));
        chk(rdata_oe_o == exp_oe, {tag, " oe"}, NS'(rdata_oe_o), NS'(exp_oe));
    endtask

    initial begin
        // Decode sweep held in reset so that no write lands.
        for (int a = 0; a < NS; a++) begin
            for (int c = 0; c < 16; c++) begin
                logic [NS-1:0] ew, er;
                logic [AW-1:0] ea;
                @(negedge clk);
                wake_i = c[0]; rd_i = c[1]; wr_i = c[2]; wr_stb_i = c[3];
                addr_i = AW'(a);
                ew = (c[0] && c[2] && c[3]) ? (NS'(1) << a) : '0;
                er = (c[0] && c[1]) ? (NS'(1) << a) : '0;
                ea = c[0] ? AW'(a) : '0;
                #1;
                chk(wsel_o == ew, "R1 wsel", wsel_o, ew);
                chk(rsel_o == er, "R2 rsel", rsel_o, er);
                chk(raw_addr_o == ea, "R3 raw", NS'(raw_addr_o), NS'(ea));
            end
        end
        idle();
        @(negedge clk) rst_n = 1;

        // R7: every register reads zero after reset.
        for (int r = 0; r < NR; r++) rd_check(r, '0, 1'b1, "R7 reset value");

        // R5, R9: write each register, read all back.
        for (int r = 0; r < NR; r++) begin
            model[r] = DW'(r * 37 + 5);
            do_write(r, model[r]);
        end
        for (int r = 0; r < NR; r++) rd_check(r, model[r], 1'b1, "R5 readback");

        // R4: unimplemented addresses and idle bus float high.
        for (int a = NR; a < NS; a += 13) rd_check(a, '1, 1'b0, "R4 unmapped");
        idle(); #1;
        chk(rdata_o == '1 && !rdata_oe_o, "R4 idle", NS'(rdata_o), NS'('1));

        // R1: strobe missing means no write.
        @(negedge clk);
        wake_i = 1; wr_i = 1; wr_stb_i = 0; addr_i = 2; wdata_i = 8'h00;
        idle(); @(negedge clk);
        rd_check(2, model[2], 1'b1, "R1 no strobe");

        // R5: timing of the commit edge.
        @(negedge clk);
        wake_i = 1; rd_i = 0; wr_i = 1; wr_stb_i = 1; addr_i = 4; wdata_i = 8'hA5;
        @(negedge clk);
        wr_i = 0; wr_stb_i = 0; rd_i = 1; #1;
        chk(rdata_o == model[4], "R5 before commit", NS'(rdata_o), NS'(model[4]));
        @(negedge clk); #1;
        chk(rdata_o == 8'hA5, "R5 after commit", NS'(rdata_o), NS'(8'hA5));
        model[4] = 8'hA5;

        // R8: same-cycle read and write of one register.
        @(negedge clk);
        wake_i = 1; rd_i = 1; wr_i = 1; wr_stb_i = 1; addr_i = 3; wdata_i = 8'h3C;
        #1;
        chk(rdata_o == model[3], "R8 old value", NS'(rdata_o), NS'(model[3]));
        idle(); @(negedge clk);
        model[3] = 8'h3C;
        rd_check(3, model[3], 1'b1, "R8 new value");

        // R6: hold-off silences reads, writes still land.
        gts_i = 1;
        rd_check(1, '1, 1'b0, "R6 held read");
        @(negedge clk);
        wake_i = 1; rd_i = 1; wr_i = 1; wr_stb_i = 1; addr_i = 1; wdata_i = 8'h77;
        #1;
        chk(rdata_o == '1 && !rdata_oe_o, "R6 held rw", NS'(rdata_o), NS'('1));
        idle(); @(negedge clk);
        model[1] = 8'h77;
        @(negedge clk) gts_i = 0;
        rd_check(1, model[1], 1'b1, "R6 write under hold");

        // R7: reset with hold-off still silences, then clears contents.
        idle();
        @(negedge clk); rst_n = 0; gts_i = 1;
        wake_i = 1; rd_i = 1; addr_i = 0; #1;
        chk(rdata_o == '1 && !rdata_oe_o, "R7 hold in reset", NS'(rdata_o), NS'('1));
        @(negedge clk); @(negedge clk); rst_n = 1; gts_i = 0;
        for (int r = 0; r < NR; r++) rd_check(r, '0, 1'b1, "R7 cleared");
        rd_check(NR, '1, 1'b0, "R9 unmapped after reset");

        idle();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule